// File: doc/BRIEF.md
# Sample Ratio Tracker with Hysteresis

The tracker measures how long an output sample period is relative to an input sample period and turns that ratio into a 4-bit scale code. A decimating filter downstream uses the code to stretch its length. Each measurement counts master clocks across `NPER` periods of each strobe and then compares the two counts against integer boundaries 1 to 15. A hysteresis margin of 1/`HYST_DIV` of the boundary is applied on both sides, so a ratio that sits on a boundary cannot make the code flicker.

Several trackers fed by the same pair of sample clocks can be made to agree. One tracker, selected with `master_sel`, drives its code onto a one-bit line. The others listen on that line and show the received code instead of their own measurement, which gives every device in the group the same filter length and so the same group delay. The master sends an 8-bit frame whenever its code changes and again every `REFRESH` cycles. Each frame is a high start bit, the code MSB first, one parity bit equal to the XOR of the code bits, and two low pad bits. The line rests low between frames. One frame bit is sent per clock, and all devices share the clock.

Each period meter has two states: `M_WAIT` waits for the first strobe and moves to `M_RUN`. `M_RUN` counts clocks and strobes, latches the total and restarts on the `NPER`th strobe. The tracker FSM moves from `T_COLLECT` to `T_DECIDE` once both meters hold a fresh total. It then returns to `T_COLLECT` after one cycle, in which it updates the code. The sender moves from `TX_IDLE` to `TX_SEND` on a change, on the first valid code or when the refresh timer runs out, and returns after 8 bits. The receiver moves from `RX_IDLE` to `RX_BITS` on a high line and returns after 7 more bits.

Top module: `srt_ratio_tracker`

## Requirements
- R1: While and after reset, before any measurement or frame completes, `scale_code` is 0, `code_valid` is 0 and `link_out` is 0.
- R2: A master with ratio r = (output period)/(input period) well away from the boundaries settles to code floor(r) for 1 <= r < 15, and to code 0 for r < 1.
- R3: The code rises only when r exceeds boundary c+1 by more than the margin, that is r > (c+1)*(HYST_DIV+1)/HYST_DIV. It then jumps to the highest boundary k exceeded by that margin.
- R4: The code falls only when r is below boundary c by more than the margin, that is r < c*(HYST_DIV-1)/HYST_DIV. It then becomes k-1, where k is the lowest boundary undercut by that margin, even when several boundaries are crossed at once.
- R5: A ratio lying exactly on a boundary keeps whichever code was held before: with r = 3.0 the code stays 2 when coming from 2.5 and stays 3 when coming from 3.125.
- R6: A master raises `code_valid` after its first complete measurement on both strobes, and it stays high.
- R7: A master frame on `link_out` is 1, code[3], code[2], code[1], code[0], XOR of the code bits, 0, 0, one bit per cycle.
- R8: A master with a valid and unchanged code starts a frame exactly every `REFRESH` cycles, and sends nothing before its code is valid.
- R9: A slave (`master_sel`=0) shows the code of the last good received frame and raises `code_valid` on it; its own strobes have no effect on its code.
- R10: A slave drops a frame whose parity bit is wrong or whose pad bits are not both 0, and keeps its previous code.
- R11: A slave keeps `link_out` low, and a master ignores frames on `link_in`.
- R12: A ratio of 15 or more by the margin gives code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock shared by all devices |
| rst_n | input | 1 | Active-low synchronous reset |
| in_strobe | input | 1 | One-cycle pulse per input sample |
| out_strobe | input | 1 | One-cycle pulse per output sample |
| master_sel | input | 1 | 1 = measure and send, 0 = adopt received code |
| link_in | input | 1 | Serial code line from the master |
| link_out | output | 1 | Serial code line to slaves |
| scale_code | output | 4 | Filter-length scale code |
| code_valid | output | 1 | Scale code is meaningful |

## Verification
The hardest case to reach is hysteresis memory. The same steady ratio must give two different codes depending on the path taken to it. The stimulus table therefore visits 2.5, 3.0, 3.125, 3.0 and 2.875 in that order, changing only the output period, and waits four measurement windows after each step so that windows mixing old and new periods have passed. Rejected frames are another corner case, because a live master always sends good ones. The bench waits for the end of a master frame and then switches the slave's line over to its own driver. It sends corrupted and then correct frames, and finally hands the line back so that the master's periodic refresh restores the slave.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int CODE_W  = 4;
    localparam int NCODE   = 1 << CODE_W;
    localparam int FRAME_W = CODE_W + 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic { M_WAIT, M_RUN } meter_state_e;
    typedef enum logic { T_COLLECT, T_DECIDE } track_state_e;
    typedef enum logic { TX_IDLE, TX_SEND } tx_state_e;
    typedef enum logic { RX_IDLE, RX_BITS } rx_state_e;
endpackage

// File: rtl/srt_period_meter.sv
module srt_period_meter #(
    parameter int NPER = 64,
    parameter int CW   = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          clear,
    output logic          fresh,
    output logic [CW-1:0] total
);
    import srt_pkg::*;
    localparam int NW = $clog2(NPER + 1);

    meter_state_e  state, state_nx;
    logic [CW-1:0] cnt;
    logic [NW-1:0] nstb;
    logic          last;

    assign last = strobe && (nstb == NW'(NPER - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            M_WAIT: if (strobe) state_nx = M_RUN;
            M_RUN:  state_nx = M_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            nstb  <= '0;
            fresh <= 1'b0;
            total <= '0;
        end else begin
            if (clear) fresh <= 1'b0;
            unique case (state)
                M_WAIT: begin
                    cnt  <= CW'(1);
                    nstb <= '0;
                end
                M_RUN: begin
                    if (last) begin
                        total <= cnt;
                        fresh <= 1'b1;
                        cnt   <= CW'(1);
                        nstb  <= '0;
                    end else begin
                        cnt <= (cnt == '1) ? cnt : cnt + CW'(1);
                        if (strobe) nstb <= nstb + NW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/srt_quantiser.sv
module srt_quantiser #(
    parameter int CW       = 24,
    parameter int HYST_DIV = 32
) (
    input  srt_pkg::code_t cur_code,
    input  logic [CW-1:0]  in_total,
    input  logic [CW-1:0]  out_total,
    output srt_pkg::code_t next_code
);
    import srt_pkg::*;
    localparam int PW = CW + CODE_W + $clog2(HYST_DIV + 2) + 2;

    logic [NCODE-1:1] up_ok;
    logic [NCODE-1:1] dn_ok;
    logic [PW-1:0]    out_scaled;
    code_t            up_cnt, dn_cnt, dn_code;

    assign out_scaled = PW'(out_total) * PW'(HYST_DIV);

    for (genvar k = 1; k < NCODE; k++) begin : g_bound
        assign up_ok[k] = out_scaled > PW'(in_total) * PW'(k * (HYST_DIV + 1));
        assign dn_ok[k] = out_scaled < PW'(in_total) * PW'(k * (HYST_DIV - 1));
    end

    always_comb begin
        up_cnt = '0;
        dn_cnt = '0;
        for (int k = 1; k < NCODE; k++) begin
            up_cnt = up_cnt + CODE_W'(up_ok[k]);
            dn_cnt = dn_cnt + CODE_W'(dn_ok[k]);
        end
        dn_code = CODE_W'(NCODE - 1) - dn_cnt;
        if (up_cnt > cur_code)       next_code = up_cnt;
        else if (dn_code < cur_code) next_code = dn_code;
        else                         next_code = cur_code;
    end
endmodule

// File: rtl/srt_link_tx.sv
module srt_link_tx #(
    parameter int REFRESH = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  srt_pkg::code_t code,
    output logic           line
);
    import srt_pkg::*;
    localparam int RW = $clog2(REFRESH + 1);

    tx_state_e            state, state_nx;
    logic [FRAME_W-1:0]   sh;
    logic [2:0]           bit_cnt;
    logic [RW-1:0]        refresh;
    code_t                sent_code;
    logic                 sent_once;
    logic                 want;

    assign want = enable && (!sent_once || code != sent_code || refresh == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (want) state_nx = TX_SEND;
            TX_SEND: if (bit_cnt == 3'd7) state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            bit_cnt   <= '0;
            refresh   <= '0;
            sent_code <= '0;
            sent_once <= 1'b0;
        end else begin
            if (refresh != '0) refresh <= refresh - RW'(1);
            unique case (state)
                TX_IDLE: if (want) begin
                    sh        <= {1'b1, code, ^code, 2'b00};
                    sent_code <= code;
                    sent_once <= 1'b1;
                    bit_cnt   <= '0;
                    refresh   <= RW'(REFRESH - 1);
                end
                TX_SEND: begin
                    sh      <= sh << 1;
                    bit_cnt <= bit_cnt + 3'd1;
                end
            endcase
        end
    end

    assign line = (state == TX_SEND) && sh[FRAME_W-1];
endmodule

// File: rtl/srt_link_rx.sv
module srt_link_rx (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line,
    output logic           good,
    output srt_pkg::code_t code,
    output logic           valid
);
    import srt_pkg::*;

    rx_state_e            state, state_nx;
    logic [FRAME_W-3:0]   sh;
    logic [2:0]           bit_cnt;
    logic [FRAME_W-2:0]   word;
    logic                 done;

    assign word = {sh, line};
    assign done = (state == RX_BITS) && (bit_cnt == 3'd6);
    assign good = done && (^word[FRAME_W-2:3] == word[2]) && (word[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (line) state_nx = RX_BITS;
            RX_BITS: if (bit_cnt == 3'd6) state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
            code    <= '0;
            valid   <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE: bit_cnt <= '0;
                RX_BITS: begin
                    sh      <= word[FRAME_W-3:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
            endcase
            if (good) begin
                code  <= word[FRAME_W-2:3];
                valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/srt_ratio_tracker.sv
module srt_ratio_tracker
    import srt_pkg::*;
#(
    parameter int NPER     = 64,
    parameter int CW       = 24,
    parameter int HYST_DIV = 32,
    parameter int REFRESH  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_strobe,
    input  logic              out_strobe,
    input  logic              master_sel,
    input  logic              link_in,
    output logic              link_out,
    output logic [CODE_W-1:0] scale_code,
    output logic              code_valid
);
    track_state_e  state, state_nx;
    logic          in_fresh, out_fresh, decide_pulse;
    logic [CW-1:0] in_total, out_total;
    code_t         next_code, own_code, rx_code;
    logic          own_valid, rx_valid, rx_good, tx_line;

    srt_period_meter #(.NPER(NPER), .CW(CW)) u_in_meter (
        .clk(clk), .rst_n(rst_n), .strobe(in_strobe), .clear(decide_pulse),
        .fresh(in_fresh), .total(in_total));

    srt_period_meter #(.NPER(NPER), .CW(CW)) u_out_meter (
        .clk(clk), .rst_n(rst_n), .strobe(out_strobe), .clear(decide_pulse),
        .fresh(out_fresh), .total(out_total));

    srt_quantiser #(.CW(CW), .HYST_DIV(HYST_DIV)) u_quant (
        .cur_code(own_code), .in_total(in_total), .out_total(out_total),
        .next_code(next_code));

    srt_link_tx #(.REFRESH(REFRESH)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(master_sel && own_valid),
        .code(own_code), .line(tx_line));

    srt_link_rx u_rx (
        .clk(clk), .rst_n(rst_n), .line(link_in), .good(rx_good),
        .code(rx_code), .valid(rx_valid));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_COLLECT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            T_COLLECT: if (in_fresh && out_fresh) state_nx = T_DECIDE;
            T_DECIDE:  state_nx = T_COLLECT;
        endcase
    end

    assign decide_pulse = (state == T_DECIDE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_code  <= '0;
            own_valid <= 1'b0;
        end else if (decide_pulse) begin
            own_code  <= next_code;
            own_valid <= 1'b1;
        end
    end

    assign scale_code = master_sel ? own_code  : rx_code;
    assign code_valid = master_sel ? own_valid : rx_valid;
    assign link_out   = master_sel && tx_line;
endmodule

// File: rtl/srt_ratio_tracker_sva.sv
module srt_ratio_tracker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       master_sel,
    input logic       link_out,
    input logic [3:0] scale_code,
    input logic       code_valid,
    input logic       decide_pulse,
    input logic       rx_good
);
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> (code_valid || master_sel != $past(master_sel)));

    assert_slave_line_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> !link_out);

    assert_no_frame_before_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !code_valid) |-> !link_out);

    assert_master_code_on_decide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && $past(master_sel) && scale_code != $past(scale_code)) |-> $past(decide_pulse));

    assert_slave_code_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !$past(master_sel) && scale_code != $past(scale_code)) |-> $past(rx_good));
endmodule

bind srt_ratio_tracker srt_ratio_tracker_sva u_sva (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .link_out(link_out),
    .scale_code(scale_code), .code_valid(code_valid),
    .decide_pulse(decide_pulse), .rx_good(rx_good));

// File: tb/srt_ratio_tracker_bench.sv
module srt_ratio_tracker_bench;
    localparam int NPER    = 4;
    localparam int REFRESH = 64;
    localparam int NV      = 9;
    localparam int TIN [NV] = '{32, 32, 32, 32, 32, 32, 32, 16, 10};
    localparam int TOUT[NV] = '{16, 48, 80, 96, 100, 96, 92, 256, 55};
    localparam int EXP [NV] = '{0, 1, 2, 2, 3, 3, 2, 15, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tin = 32, tout = 16;
    int icnt = 0, ocnt = 0, sicnt = 0, socnt = 0;
    logic m_in = 0, m_out = 0, s_in = 0, s_out = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            icnt = 0; ocnt = 0; sicnt = 0; socnt = 0;
            m_in = 0; m_out = 0; s_in = 0; s_out = 0;
        end else begin
            icnt++;  m_in  = (icnt >= tin);   if (m_in)  icnt = 0;
            ocnt++;  m_out = (ocnt >= tout);  if (m_out) ocnt = 0;
            sicnt++; s_in  = (sicnt >= 20);   if (s_in)  sicnt = 0;
            socnt++; s_out = (socnt >= 140);  if (s_out) socnt = 0;
        end
    end

    logic m_link, s_link, m_valid, s_valid, m_junk = 0, ovr = 0, bline = 0;
    logic [3:0] m_code, s_code;

    srt_ratio_tracker #(.NPER(NPER), .REFRESH(REFRESH)) u_srt_ratio_tracker (
        .clk(clk), .rst_n(rst_n), .in_strobe(m_in), .out_strobe(m_out),
        .master_sel(1'b1), .link_in(m_junk), .link_out(m_link),
        .scale_code(m_code), .code_valid(m_valid));

    srt_ratio_tracker #(.NPER(NPER), .REFRESH(REFRESH)) u_slave (
        .clk(clk), .rst_n(rst_n), .in_strobe(s_in), .out_strobe(s_out),
        .master_sel(1'b0), .link_in(ovr ? bline : m_link), .link_out(s_link),
        .scale_code(s_code), .code_valid(s_valid));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic grab_frame(output logic [6:0] bits, output int unsigned at);
        do @(negedge clk); while (m_link !== 1'b1);
        at = cyc;
        bits = '0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            bits = {bits[5:0], m_link};
        end
    endtask

    task automatic send_frame(input logic [7:0] f, input bit to_master);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            if (to_master) m_junk = f[i]; else bline = f[i];
        end
        @(negedge clk);
        m_junk = 0; bline = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all requirements actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] fr;
        int unsigned t1, t2;
        int unsigned slow;
        repeat (5) @(negedge clk);
        check("R1 reset code", m_code, 0);
        check("R1 reset valid", m_valid, 0);
        check("R1 reset link", m_link, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check("R1 master valid before first window", m_valid, 0);
        check("R8 no frame before valid", m_link, 0);
        check("R1 slave valid before frame", s_valid, 0);

        for (int v = 0; v < NV; v++) begin
            tin = TIN[v]; tout = TOUT[v];
            slow = (TIN[v] > TOUT[v]) ? TIN[v] : TOUT[v];
            repeat (4 * NPER * slow + 60) @(negedge clk);
            check($sformatf("R2 R3 R4 R5 R12 master code vector %0d", v), m_code, EXP[v]);
            check($sformatf("R9 slave adopts vector %0d", v), s_code, EXP[v]);
            check($sformatf("R11 slave line low vector %0d", v), s_link, 0);
        end
        check("R6 master valid", m_valid, 1);
        check("R9 slave valid", s_valid, 1);

        grab_frame(fr, t1);
        check("R7 frame bits code 5", fr, 7'b0101000);
        grab_frame(fr, t2);
        check("R8 refresh interval", t2 - t1, REFRESH);

        send_frame({1'b1, 4'd9, 1'b0, 2'b00}, 1'b1);
        check("R11 master ignores link_in", m_code, 5);

        grab_frame(fr, t1);
        ovr = 1;
        send_frame({1'b1, 4'd9, 1'b1, 2'b00}, 1'b0);
        check("R10 bad parity held", s_code, 5);
        send_frame({1'b1, 4'd9, 1'b0, 2'b01}, 1'b0);
        check("R10 bad pad held", s_code, 5);
        send_frame({1'b1, 4'd9, 1'b0, 2'b00}, 1'b0);
        check("R9 good frame taken", s_code, 9);
        send_frame({1'b1, 4'd6, 1'b0, 2'b00}, 1'b0);
        check("R9 second good frame taken", s_code, 6);
        grab_frame(fr, t1);
        ovr = 0;
        repeat (REFRESH + 20) @(negedge clk);
        check("R8 refresh restores slave", s_code, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule